// File: doc/BRIEF.md
# I2C Bit-Rate Divider Solver

This block turns an input clock frequency and a requested serial bit rate into the two settings that a two-wire bus master's baud generator needs. The first is a prescaler select that picks a predivide of 32, 16, 8 or 4. The second is an 8-bit divider. The block steps through the four prescaler settings one after another. For each one it derives a candidate divider and throws the candidate away if it does not fit in eight bits. It then works out the bit rate that the candidate would really give. The result it keeps is the fastest one that does not go above the request.

All of the arithmetic runs on one shared iterative restoring divider, which produces one quotient bit per cycle. A single-cycle `start` pulse begins a search, and a single-cycle `done` pulse ends it. When the search ends, the block publishes a mode byte, a divider byte, the achieved rate and a found flag. It then drives a tick generator that pulses at twice the serial clock rate while `tickEn` is high, which gives the half-period strobe a bit engine needs.

Top module: `i2cRateSolver`

## Requirements
- R1: Prescaler select s (0 to 3) gives a predivide P = 32 >> s. With the published settings, one serial clock period lasts P × 2 × (D + 3 + 2F) input clocks, where D is the divider and F is the filter term.
- R2: The candidate divider for select s is D = ((ceil(clk / (P × rate)) + 1) >> 1) − 3 − 2F. The filter term F is 0 throughout the search.
- R3: A candidate whose D falls below 0 or above 255 is rejected. D = 0 and D = 255 are both still accepted.
- R4: The achieved rate of a candidate is floor(clk / (P × 2 × (D + 3))). A candidate is kept only if this rate is at or below the request and its shortfall is strictly below the best shortfall so far. The best shortfall starts at the request, so on a tie the lower select wins.
- R5: When no candidate qualifies, the select, divider, filter and achieved rate all read 0 and `found` reads 0.
- R6: `modeReg` carries the select in bits 2:1 and the filter in bit 3. Bit 0 and bits 7:4 read 0. `divReg` holds the 8-bit divider.
- R7: `start` while idle latches `clkHz` and `rateHz` and raises `busy` on the next cycle. `done` is a one-cycle pulse in the first idle cycle after the search. A `start` given while `busy` is ignored.
- R8: After at least one completed search and while `tickEn` is high, `sclTick` pulses for one cycle every P × (D + 3 + 2F) cycles. While `tickEn` is low it stays 0.
- R9: After reset, `busy`, `done`, `modeReg`, `divReg`, `achievedHz`, `found` and `sclTick` are all 0. No tick appears until a search has completed.
- R10: Published results change only in the cycle that `done` is high. During a search the tick keeps the interval from the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a search |
| clkHz | input | FREQ_W | Input clock frequency in Hz |
| rateHz | input | FREQ_W | Requested bit rate in Hz |
| tickEn | input | 1 | Enables the tick generator |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| modeReg | output | 8 | Mode byte: select in bits 2:1, filter in bit 3 |
| divReg | output | 8 | Divider byte |
| achievedHz | output | FREQ_W | Bit rate reached by the published settings |
| found | output | 1 | A candidate qualified in the last search |
| sclTick | output | 1 | Pulse at twice the serial clock rate |

## Verification
The tick generator and the search can both be active in the same cycle. A search started while ticks are running must not disturb the tick interval until `done`. The bench provokes this case in three steps. It first publishes a setting with a very short interval and enables ticks. It then launches a new search and measures one full tick interval while `busy` is still high, expecting the old interval. Once `done` has arrived, it lets one mixed interval pass and then expects the new interval. The same overlap question also covers a second `start` given while `busy`: the bench changes the inputs with that start and expects the result of the first request.

// File: rtl/i2cRateSolverPkg.sv
package i2cRateSolverPkg;
  // offset added to the divider inside the period formula
  localparam int BASE_OFFSET = 3;
  // glitch-filter term, fixed during the search
  localparam int FILTER_TERM = 0;
  localparam int SEL_LAST    = 3;

  typedef struct packed {
    logic loadReq;     // latch inputs, clear best candidate
    logic launchCeil;  // start ceil(clk / (P*rate)) division
    logic launchRate;  // start clk / period division
    logic evalCand;    // judge candidate divider range
    logic scoreCand;   // compare achieved rate with best
    logic nextSel;     // advance prescaler select
    logic publish;     // copy best candidate to outputs
  } solverStrobe_t;
endpackage

// File: rtl/iterDivider.sv
module iterDivider #(
  parameter int W = 38
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         fin
);
  localparam int CW = $clog2(W);

  logic [W:0]    rem;
  logic [W-1:0]  dd;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    trial;
  logic          fits;

  always_comb begin
    trial = {rem[W-1:0], quo[W-1]};
    fits  = (trial >= {1'b0, dd});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rem <= '0;
      quo <= '0;
      dd  <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem <= '0;
        quo <= num;
        dd  <= den;
        cnt <= CW'(W - 1);
        run <= 1'b1;
      end else if (run) begin
        rem <= fits ? (trial - {1'b0, dd}) : trial;
        quo <= {quo[W-2:0], fits};
        if (cnt == '0) begin
          run <= 1'b0;
          fin <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R2: each division signals its end once
  a_r2_fin_single: assert property (@(posedge clk) disable iff (!rstN)
    fin |=> !fin);
  // R2: a finished division is not still running
  a_r2_fin_idle: assert property (@(posedge clk) disable iff (!rstN)
    fin |-> !run);
endmodule

// File: rtl/solverCtrl.sv
module solverCtrl
  import i2cRateSolverPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          divFin,
  input  logic          candOk,
  input  logic          lastSel,
  output solverStrobe_t st,
  output logic          busy,
  output logic          done
);
  typedef enum logic [2:0] {
    S_IDLE, S_CEIL_GO, S_CEIL_WAIT, S_CHECK,
    S_RATE_GO, S_RATE_WAIT, S_ADVANCE, S_PUBLISH
  } solverState_t;

  solverState_t state, nxt;

  always_comb begin
    st  = '0;
    nxt = state;
    unique case (state)
      S_IDLE: if (start) begin
        st.loadReq = 1'b1;
        nxt = S_CEIL_GO;
      end
      S_CEIL_GO: begin
        st.launchCeil = 1'b1;
        nxt = S_CEIL_WAIT;
      end
      S_CEIL_WAIT: if (divFin) begin
        st.evalCand = 1'b1;
        nxt = S_CHECK;
      end
      S_CHECK: nxt = candOk ? S_RATE_GO : S_ADVANCE;
      S_RATE_GO: begin
        st.launchRate = 1'b1;
        nxt = S_RATE_WAIT;
      end
      S_RATE_WAIT: if (divFin) begin
        st.scoreCand = 1'b1;
        nxt = S_ADVANCE;
      end
      S_ADVANCE: begin
        if (lastSel) nxt = S_PUBLISH;
        else begin
          st.nextSel = 1'b1;
          nxt = S_CEIL_GO;
        end
      end
      S_PUBLISH: begin
        st.publish = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == S_PUBLISH);
    end
  end

  assign busy = (state != S_IDLE);

  // R7: end-of-search pulse lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: done follows a busy cycle and lands in idle
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
  // R7: a start seen while idle makes the block busy next cycle
  a_r7_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
endmodule

// File: rtl/solverDatapath.sv
module solverDatapath
  import i2cRateSolverPkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int W      = FREQ_W + 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  solverStrobe_t     st,
  input  logic [FREQ_W-1:0] clkHz,
  input  logic [FREQ_W-1:0] rateHz,
  input  logic              tickEn,
  input  logic [W-1:0]      divQuo,
  output logic              divGo,
  output logic [W-1:0]      divNum,
  output logic [W-1:0]      divDen,
  output logic              candOk,
  output logic              lastSel,
  output logic [7:0]        modeReg,
  output logic [7:0]        divReg,
  output logic [FREQ_W-1:0] achievedHz,
  output logic              found,
  output logic              sclTick
);
  localparam int OFFS = BASE_OFFSET + 2 * FILTER_TERM;
  localparam int PW   = 16;

  logic [1:0]        sel;
  logic [FREQ_W-1:0] clkL, rateL;
  logic [W-1:0]      preW, denCeil, numCeil, perDen, halfR, rateW;
  logic [W:0]        halfN;
  logic              candOkNow, better, okR;

  logic [FREQ_W-1:0] bestDiff, bestAch;
  logic [1:0]        bestSel;
  logic [7:0]        bestDiv;
  logic              bestFound;

  logic [1:0]        pubSel;
  logic [7:0]        pubDiv;
  logic [FREQ_W-1:0] pubAch;
  logic              pubFound, cfgValid;

  logic [PW-1:0]     preP, halfPer, tickCnt;

  // candidate arithmetic
  always_comb begin
    preW      = W'(32) >> sel;
    rateW     = W'(rateL);
    denCeil   = preW * rateW;
    numCeil   = W'(clkL) + denCeil - W'(1);
    perDen    = (preW * halfR) << 1;
    halfN     = ({1'b0, divQuo} + (W+1)'(1)) >> 1;
    candOkNow = (halfN >= (W+1)'(OFFS)) &&
                ((halfN - (W+1)'(OFFS)) <= (W+1)'(255));
    better    = (divQuo <= rateW) && ((rateW - divQuo) < W'(bestDiff));
    divGo     = st.launchCeil | st.launchRate;
    divNum    = st.launchCeil ? numCeil : W'(clkL);
    divDen    = st.launchCeil ? denCeil : perDen;
  end

  assign candOk  = okR;
  assign lastSel = (sel == 2'(SEL_LAST));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sel <= '0; clkL <= '0; rateL <= '0;
      halfR <= '0; okR <= 1'b0;
      bestDiff <= '0; bestAch <= '0; bestSel <= '0; bestDiv <= '0;
      bestFound <= 1'b0;
      pubSel <= '0; pubDiv <= '0; pubAch <= '0; pubFound <= 1'b0;
      cfgValid <= 1'b0;
    end else begin
      if (st.loadReq) begin
        clkL      <= clkHz;
        rateL     <= rateHz;
        sel       <= '0;
        bestDiff  <= rateHz;
        bestAch   <= '0;
        bestSel   <= '0;
        bestDiv   <= '0;
        bestFound <= 1'b0;
      end
      if (st.evalCand) begin
        okR   <= candOkNow;
        halfR <= halfN[W-1:0];
      end
      if (st.scoreCand && better) begin
        bestDiff  <= FREQ_W'(rateW - divQuo);
        bestAch   <= FREQ_W'(divQuo);
        bestSel   <= sel;
        bestDiv   <= 8'(halfR - W'(OFFS));
        bestFound <= 1'b1;
      end
      if (st.nextSel) sel <= sel + 2'd1;
      if (st.publish) begin
        pubSel   <= bestSel;
        pubDiv   <= bestDiv;
        pubAch   <= bestAch;
        pubFound <= bestFound;
        cfgValid <= 1'b1;
      end
    end
  end

  assign modeReg    = {4'b0000, 1'(FILTER_TERM), pubSel, 1'b0};
  assign divReg     = pubDiv;
  assign achievedHz = pubAch;
  assign found      = pubFound;

  // half-period tick generator
  always_comb begin
    preP    = PW'(32) >> pubSel;
    halfPer = preP * (PW'(pubDiv) + PW'(OFFS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      sclTick <= 1'b0;
    end else if (!cfgValid || !tickEn) begin
      tickCnt <= halfPer - PW'(1);
      sclTick <= 1'b0;
    end else if (tickCnt == '0) begin
      tickCnt <= halfPer - PW'(1);
      sclTick <= 1'b1;
    end else begin
      tickCnt <= tickCnt - PW'(1);
      sclTick <= 1'b0;
    end
  end

  // R3: only in-range candidates reach scoring
  a_r3_scored_in_range: assert property (@(posedge clk) disable iff (!rstN)
    st.scoreCand |-> okR);
  // R4: published rate never exceeds the latched request
  a_r4_not_above: assert property (@(posedge clk) disable iff (!rstN)
    st.publish |=> (!pubFound || (pubAch <= rateL)));
  // R5: an empty search publishes zeros
  a_r5_zero_default: assert property (@(posedge clk) disable iff (!rstN)
    st.publish |=> (pubFound || (pubSel == 2'd0 && pubDiv == 8'd0 && pubAch == '0)));
  // R8: ticks need the enable and a finished search
  a_r8_tick_gated: assert property (@(posedge clk) disable iff (!rstN)
    sclTick |-> ($past(tickEn) && $past(cfgValid)));
  // R8: ticks are single-cycle pulses
  a_r8_tick_single: assert property (@(posedge clk) disable iff (!rstN)
    sclTick |=> !sclTick);
  // R10: published values move only on publish
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(st.publish) |-> ($stable(pubSel) && $stable(pubDiv)));
endmodule

// File: rtl/i2cRateSolver.sv
module i2cRateSolver
  import i2cRateSolverPkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FREQ_W-1:0] clkHz,
  input  logic [FREQ_W-1:0] rateHz,
  input  logic              tickEn,
  output logic              busy,
  output logic              done,
  output logic [7:0]        modeReg,
  output logic [7:0]        divReg,
  output logic [FREQ_W-1:0] achievedHz,
  output logic              found,
  output logic              sclTick
);
  localparam int QW = FREQ_W + 6;

  solverStrobe_t st;
  logic          divGo, divFin, candOk, lastSel;
  logic [QW-1:0] divNum, divDen, divQuo;

  solverCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .divFin(divFin),
    .candOk(candOk), .lastSel(lastSel), .st(st), .busy(busy), .done(done)
  );

  solverDatapath #(.FREQ_W(FREQ_W), .W(QW)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .clkHz(clkHz), .rateHz(rateHz),
    .tickEn(tickEn), .divQuo(divQuo), .divGo(divGo), .divNum(divNum),
    .divDen(divDen), .candOk(candOk), .lastSel(lastSel),
    .modeReg(modeReg), .divReg(divReg), .achievedHz(achievedHz),
    .found(found), .sclTick(sclTick)
  );

  iterDivider #(.W(QW)) u_div (
    .clk(clk), .rstN(rstN), .go(divGo), .num(divNum), .den(divDen),
    .quo(divQuo), .fin(divFin)
  );
endmodule

// File: tb/test_i2cRateSolver.sv
module test_i2cRateSolver;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int FREQ_W = 32;
  localparam int NV = 10;
  localparam longint VCLK [NV] = '{
    100000000, 100000000, 33000000, 66000000, 8000000,
    16512000,  16576000,  24000000, 100000000, 10000000 };
  localparam longint VRATE[NV] = '{
    100000, 400000, 400000, 50000, 10000,
    1000,   1000,   1000000, 1000, 1000000 };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, tickEn = 1'b0;
  logic [FREQ_W-1:0] clkHz = '0, rateHz = '0;
  logic busy, done, found, sclTick;
  logic [7:0] modeReg, divReg;
  logic [FREQ_W-1:0] achievedHz;

  int nChecks = 0, nFails = 0;

  always #4 clk = ~clk;

  i2cRateSolver #(.FREQ_W(FREQ_W)) i_i2cRateSolver (
    .clk(clk), .rstN(rstN), .start(start), .clkHz(clkHz), .rateHz(rateHz),
    .tickEn(tickEn), .busy(busy), .done(done), .modeReg(modeReg),
    .divReg(divReg), .achievedHz(achievedHz), .found(found), .sclTick(sclTick)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void refSolve(input longint c, input longint r,
                                   output int eSel, output int eDiv,
                                   output longint eAch, output bit eFound);
    longint best;
    best = r; eSel = 0; eDiv = 0; eAch = 0; eFound = 0;
    for (int s = 0; s < 4; s++) begin
      longint pre, den, q1, half, b, ach, diff;
      pre = 32 >> s;
      den = pre * r;
      if (den == 0) q1 = (longint'(1) << 38) - 1;
      else q1 = (c + den - 1) / den;
      half = (q1 + 1) / 2;
      b = half - 3;
      if (b >= 0 && b <= 255) begin
        ach  = c / (pre * 2 * half);
        diff = r - ach;
        if (diff >= 0 && diff < best) begin  // strict: tie keeps lower select
          best = diff; eSel = s; eDiv = int'(b); eAch = ach; eFound = 1;
        end
      end
    end
  endfunction

  task automatic pulseStart(input longint c, input longint r);
    @(negedge clk);
    clkHz = FREQ_W'(c); rateHz = FREQ_W'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R7 done seen", done, 1);
  endtask

  task automatic checkResult(input longint c, input longint r, input string tag);
    int eSel, eDiv; longint eAch; bit eFound;
    refSolve(c, r, eSel, eDiv, eAch, eFound);
    check(found == eFound, {tag, " R4/R5 found"}, found, eFound);
    check(modeReg == 8'({eSel[1:0], 1'b0}), {tag, " R6 R1 modeReg"}, modeReg, {eSel[1:0], 1'b0});
    check(divReg == 8'(eDiv), {tag, " R2 R3 divReg"}, divReg, eDiv);
    check(achievedHz == FREQ_W'(eAch), {tag, " R4 achievedHz"}, achievedHz, eAch);
  endtask

  task automatic measureGap(output int gap);
    int w = 0;
    while (!sclTick && w < 20000) begin @(negedge clk); w++; end
    gap = 0;
    do begin @(negedge clk); gap++; end while (!sclTick && gap < 20000);
  endtask

  initial begin
    #(8 * 190000);
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int gap, cnt, eSel, eDiv; longint eAch; bit eFound;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(busy == 0 && done == 0, "R9 idle after reset", {busy, done}, 0);
    check(modeReg == 0 && divReg == 0, "R9 zero registers", {modeReg, divReg}, 0);
    check(achievedHz == 0 && found == 0, "R9 zero result", achievedHz, 0);
    tickEn = 1'b1; cnt = 0;
    repeat (300) begin @(negedge clk); if (sclTick) cnt++; end
    check(cnt == 0, "R9 R8 no tick before first search", cnt, 0);
    tickEn = 1'b0;

    // vector table
    for (int i = 0; i < NV; i++) begin
      pulseStart(VCLK[i], VRATE[i]);
      check(busy == 1'b1, "R7 busy after start", busy, 1);
      waitDone();
      checkResult(VCLK[i], VRATE[i], $sformatf("vec%0d", i));
    end

    // R3 boundaries, named explicitly
    pulseStart(16512000, 1000); waitDone();
    check(found == 1 && divReg == 255, "R3 divider 255 accepted", divReg, 255);
    pulseStart(16576000, 1000); waitDone();
    check(found == 0, "R3 divider 256 rejected", found, 0);
    pulseStart(24000000, 1000000); waitDone();
    check(found == 1 && divReg == 0 && modeReg == 8'h06, "R3 divider 0 accepted", divReg, 0);
    // R4 tie: selects 1,2,3 all exact, lower kept
    pulseStart(8000000, 10000); waitDone();
    check(modeReg == 8'h02 && divReg == 22, "R4 tie keeps lower select", modeReg, 2);
    // R5 zero rate
    pulseStart(50000000, 0); waitDone();
    check(found == 0 && modeReg == 0 && divReg == 0 && achievedHz == 0, "R5 zero defaults", found, 0);

    // R7 start while busy ignored
    pulseStart(8000000, 10000);
    repeat (40) @(negedge clk);
    clkHz = 100000000; rateHz = 100000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitDone();
    check(modeReg == 8'h02 && divReg == 22, "R7 second start ignored", divReg, 22);
    @(negedge clk);
    check(busy == 0, "R7 idle after ignored start", busy, 0);

    // R8 tick interval P*(D+3)=16*25
    tickEn = 1'b1;
    measureGap(gap);
    check(gap == 400, "R8 R1 tick interval", gap, 400);
    tickEn = 1'b0; cnt = 0;
    repeat (1000) begin @(negedge clk); if (sclTick) cnt++; end
    check(cnt == 0, "R8 no tick when disabled", cnt, 0);

    // R5/R8 defaults give 32*3
    pulseStart(100000000, 1000); waitDone();
    tickEn = 1'b1;
    measureGap(gap);
    check(gap == 96, "R8 R5 default tick interval", gap, 96);

    // R10 overlap: short interval, then search runs beside ticks
    tickEn = 1'b0;
    pulseStart(24000000, 1000000); waitDone();
    tickEn = 1'b1;
    measureGap(gap);
    check(gap == 12, "R10 short interval", gap, 12);
    pulseStart(100000000, 100000);
    measureGap(gap);
    check(gap == 12 && busy == 1, "R10 old interval during search", gap, 12);
    waitDone();
    refSolve(100000000, 100000, eSel, eDiv, eAch, eFound);
    measureGap(gap);
    measureGap(gap);
    check(gap == (32 >> eSel) * (eDiv + 3), "R10 R1 new interval after done", gap, (32 >> eSel) * (eDiv + 3));

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule